// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from its module clock. A 32-bit clock-control word picks one of two ways to set the half-period. In the linear mode an 8-bit count N gives a half-period of N+1 module-clock cycles. In the power-of-two mode a 4-bit exponent M gives a half-period of 2^M cycles. Besides the serial clock, the block emits two single-cycle pulses. One marks the edge where the serial clock leaves its rest level (the leading edge). The other marks the edge where it comes back (the trailing edge). The shift engine uses these pulses to sample and launch data.

The divider has two states. In `ST_IDLE` the block samples the control word and the CPOL input on every cycle, and the serial clock rests at the sampled CPOL level. The transition *start* (IDLE to RUN) is taken on the first clock edge where `xfer_active` is high. In `ST_RUN` the half-period counter runs and the clock toggles. The transition *stop* (RUN to IDLE) is taken on the first edge where `xfer_active` is low. Because the control word and CPOL are sampled only in `ST_IDLE`, a change to either one during a transfer cannot shorten or stretch a clock phase.

Top module: `spi_sclk_div`

## Requirements
- R1: With `clk_ctl[12]` = 1 (linear mode), the serial clock half-period is N+1 module-clock cycles, where N = `clk_ctl[7:0]`.
- R2: With `clk_ctl[12]` = 0 (power-of-two mode), the half-period is 2^M cycles, where M = `clk_ctl[11:8]`.
- R3: Linear mode with N = 0 toggles `sclk` on every module-clock edge, which is half the module clock rate.
- R4: Bits 31:13 of `clk_ctl` are ignored, and so is the divide field of the mode that is not selected.
- R5: In ST_IDLE, `sclk` equals the CPOL value sampled on the previous edge, and neither pulse is raised.
- R6: The control word and CPOL are captured only in ST_IDLE. Changing either one in ST_RUN has no effect on `sclk` or the pulses.
- R7: The first toggle comes exactly one half-period after the edge that takes the start transition. `lead_pulse` is high during the cycle in which `sclk` has just left the rest level, and `trail_pulse` is high during the cycle in which it has just returned.
- R8: Each pulse lasts one cycle. The pulses never coincide, they alternate strictly, and the first pulse of every transfer is a lead pulse.
- R9: With M = 15 the half-period is a full 32768 cycles, so the counter does not wrap early.
- R10: On the edge that takes the stop transition, `sclk` returns to rest. A following transfer begins again with a full first half-period.
- R11: After reset, `sclk` is 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctl | input | 32 | Clock-control word: bit 12 mode select, bits 11:8 exponent, bits 7:0 linear count |
| xfer_active | input | 1 | High while a transfer runs |
| cpol | input | 1 | Rest level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle mark of the edge that leaves the rest level |
| trail_pulse | output | 1 | One-cycle mark of the edge that returns to the rest level |

## Verification
A wrong captured limit or a miscounting half-period timer shows up as a misplaced first toggle. It becomes visible on `sclk` one half-period after the start transition, and the bench compares every cycle, so the error is caught at that cycle. A phase register that fails to clear on stop shows up either as `sclk` away from rest on the first idle cycle or as a trailing pulse at the start of the next transfer. A capture that is not blocked in ST_RUN shows up within one half-period after the mid-transfer change, as a toggle spacing that differs from the period computed in the bench.

// File: rtl/spi_sdiv_pkg.sv
package spi_sdiv_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_cfg_capture.sv
module sdiv_cfg_capture #(
    parameter int CTL_W   = 32,
    parameter int LIN_W   = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_LSB = 8,
    parameter int SEL_BIT = 12,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CTL_W-1:0] ctl,
    input  logic             cpol,
    output logic [CNT_W-1:0] lim_q,
    output logic             pol_q
);
    logic [CNT_W-1:0] lim_next;
    logic             unused_ctl;

    assign unused_ctl = ^ctl;

    // Half-period minus one, for whichever mode the select bit picks
    always_comb begin
        if (ctl[SEL_BIT])
            lim_next = CNT_W'(ctl[LIN_W-1:0]);
        else
            lim_next = (CNT_W'(1) << ctl[EXP_LSB +: EXP_W]) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
            pol_q <= 1'b0;
        end else if (capture) begin
            lim_q <= lim_next;
            pol_q <= cpol;
        end
    end

    // R6: captured values hold while capture is closed
    a_r6_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> ($stable(lim_q) && $stable(pol_q)));
endmodule

// File: rtl/sdiv_half_timer.sv
module sdiv_half_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R9: the counter never passes the limit while running
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

    // R6: the limit does not move during a run
    a_r6_limit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(lim));
endmodule

// File: rtl/sdiv_edge_fsm.sv
module sdiv_edge_fsm
    import spi_sdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic tick,
    output logic run,
    output logic phase_q,
    output logic lead_q,
    output logic trail_q
);
    sdiv_state_e state_q, state_d;
    logic        owed_trail_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (xfer_active)  state_d = ST_RUN;
            ST_RUN:  if (!xfer_active) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign run = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    phase_q <= 1'b0;
                    lead_q  <= 1'b0;
                    trail_q <= 1'b0;
                end
                ST_RUN: begin
                    if (!xfer_active) begin
                        phase_q <= 1'b0;
                        lead_q  <= 1'b0;
                        trail_q <= 1'b0;
                    end else if (tick) begin
                        phase_q <= ~phase_q;
                        lead_q  <= ~phase_q;
                        trail_q <= phase_q;
                    end else begin
                        lead_q  <= 1'b0;
                        trail_q <= 1'b0;
                    end
                end
                default: begin
                    phase_q <= 1'b0;
                    lead_q  <= 1'b0;
                    trail_q <= 1'b0;
                end
            endcase
        end
    end

    // Tracks whether a trail pulse is due, for the alternation checks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            owed_trail_q <= 1'b0;
        else if (!run)
            owed_trail_q <= 1'b0;
        else if (lead_q)
            owed_trail_q <= 1'b1;
        else if (trail_q)
            owed_trail_q <= 1'b0;
    end

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_q && trail_q));
    a_r8_lead_order: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lead_q) |-> !owed_trail_q);
    a_r8_trail_order: assert property (@(posedge clk) disable iff (!rst_n)
        (run && trail_q) |-> owed_trail_q);
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!lead_q && !trail_q && !phase_q));
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
    parameter int CTL_W   = 32,
    parameter int LIN_W   = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_LSB = 8,
    parameter int SEL_BIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] clk_ctl,
    input  logic             xfer_active,
    input  logic             cpol,
    output logic             sclk,
    output logic             lead_pulse,
    output logic             trail_pulse
);
    localparam int EXP_CNT_W = (1 << EXP_W);
    localparam int LIN_CNT_W = LIN_W + 1;
    localparam int CNT_W     = (EXP_CNT_W > LIN_CNT_W) ? EXP_CNT_W : LIN_CNT_W;

    logic             run;
    logic             tick;
    logic             phase;
    logic             pol_q;
    logic [CNT_W-1:0] lim;

    sdiv_cfg_capture #(
        .CTL_W  (CTL_W),
        .LIN_W  (LIN_W),
        .EXP_W  (EXP_W),
        .EXP_LSB(EXP_LSB),
        .SEL_BIT(SEL_BIT),
        .CNT_W  (CNT_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(!run),
        .ctl    (clk_ctl),
        .cpol   (cpol),
        .lim_q  (lim),
        .pol_q  (pol_q)
    );

    sdiv_half_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .lim  (lim),
        .tick (tick)
    );

    sdiv_edge_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .tick       (tick),
        .run        (run),
        .phase_q    (phase),
        .lead_q     (lead_pulse),
        .trail_q    (trail_pulse)
    );

    assign sclk = pol_q ^ phase;

    // R7: within a run, every serial clock change carries a pulse
    a_r7_edge_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (sclk != $past(sclk))) |-> (lead_pulse || trail_pulse));
    // R7: a lead pulse leaves sclk off the rest level, a trail pulse on it
    a_r7_lead_level: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |-> (sclk != pol_q));
    a_r7_trail_level: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |-> (sclk == pol_q));
endmodule

// File: tb/sim_spi_sclk_div.sv
`timescale 1ns/1ps
module sim_spi_sclk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] clk_ctl = 32'h0;
    logic        xfer_active = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk, lead_pulse, trail_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_sclk_div u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_ctl    (clk_ctl),
        .xfer_active(xfer_active),
        .cpol       (cpol),
        .sclk       (sclk),
        .lead_pulse (lead_pulse),
        .trail_pulse(trail_pulse)
    );

    localparam logic [31:0] JUNK_HI = 32'hA5A5_6000;

    function automatic logic [31:0] lin_word(input int n, input bit junk);
        return (junk ? (JUNK_HI | 32'h0000_0F00) : 32'h0) | 32'h1000 | (32'(n) & 32'hFF);
    endfunction

    function automatic logic [31:0] exp_word(input int m, input bit junk);
        return (junk ? (JUNK_HI | 32'h0000_00C3) : 32'h0) | ((32'(m) & 32'hF) << 8);
    endfunction

    // Runs one transfer, compares every cycle against the arithmetic model
    task automatic run_cfg(input logic [31:0] ctl, input bit pol, input int half,
                           input int ncyc, input bit chg, input string tag);
        int bad;
        bit e_sclk, e_lead, e_trail;
        int t, toggles;
        bad = 0;
        @(negedge clk);
        clk_ctl = ctl; cpol = pol; xfer_active = 1'b0;
        @(negedge clk); @(negedge clk);
        checks++;
        if (sclk !== pol || lead_pulse !== 1'b0 || trail_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R5 idle: sclk=%b lead=%b trail=%b exp sclk=%b lead=0 trail=0",
                     sclk, lead_pulse, trail_pulse, pol);
        end
        xfer_active = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            t = k - 1;
            toggles = t / half;
            e_sclk  = pol ^ toggles[0];
            e_lead  = (t > 0) && (t % half == 0) && toggles[0];
            e_trail = (t > 0) && (t % half == 0) && !toggles[0];
            if (sclk !== e_sclk || lead_pulse !== e_lead || trail_pulse !== e_trail) begin
                if (bad == 0)
                    $display("FAIL %s k=%0d: sclk=%b lead=%b trail=%b exp sclk=%b lead=%b trail=%b",
                             tag, k, sclk, lead_pulse, trail_pulse, e_sclk, e_lead, e_trail);
                bad++;
            end
            if (chg && k == ncyc / 2) begin
                clk_ctl = exp_word(0, 1'b0);
                cpol = ~pol;
            end
        end
        checks++;
        if (bad != 0) errors++;
        cpol = pol;
        clk_ctl = ctl;
        xfer_active = 1'b0;
        @(negedge clk);
        checks++;
        if (sclk !== pol || lead_pulse !== 1'b0 || trail_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R10 stop: sclk=%b lead=%b trail=%b exp sclk=%b lead=0 trail=0",
                     sclk, lead_pulse, trail_pulse, pol);
        end
        bad = 0;
        for (int k = 0; k < half + 3; k++) begin
            @(negedge clk);
            if (sclk !== pol || lead_pulse !== 1'b0 || trail_pulse !== 1'b0) bad++;
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL R5 idle hold: %0d bad cycles, exp 0", bad);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d exp below 190000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (sclk !== 1'b0 || lead_pulse !== 1'b0 || trail_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: sclk=%b lead=%b trail=%b exp 0 0 0",
                     sclk, lead_pulse, trail_pulse);
        end
        rst_n = 1'b1;

        // R3: fastest linear rate
        run_cfg(lin_word(0, 1'b0), 1'b0, 1, 10, 1'b0, "R3 R7 R8");
        run_cfg(lin_word(0, 1'b1), 1'b1, 1, 10, 1'b0, "R3 R4");
        // R1: linear sweep, both polarities, with and without junk bits
        for (int n = 1; n < 10; n++)
            run_cfg(lin_word(n, n[0]), n[1], n + 1, 6 * (n + 1) + 3, 1'b0, "R1 R7 R8");
        run_cfg(lin_word(255, 1'b1), 1'b0, 256, 1100, 1'b0, "R1 R4");
        // R2: power-of-two sweep
        for (int m = 0; m < 6; m++)
            run_cfg(exp_word(m, m[0]), m[1], 1 << m, 6 * (1 << m) + 3, 1'b0, "R2 R4 R8");
        // R6: mid-transfer change of word and polarity is ignored
        run_cfg(lin_word(3, 1'b0), 1'b1, 4, 40, 1'b1, "R6");
        run_cfg(exp_word(2, 1'b1), 1'b0, 4, 40, 1'b1, "R6 R10");
        // R9: longest exponent
        run_cfg(exp_word(15, 1'b0), 1'b1, 32768, 65540, 1'b0, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule